// File: doc/BRIEF.md
# Bank-Aware Memory Command Scheduler

This block sits between requesters and a multi-bank synchronous DRAM. Read and write requests are accepted into two separate eight-entry queues. Every cycle, at most one of them is turned into a command for the memory. A per-bank busy timer holds each bank off for six cycles after it receives a command. Among the queued reads, the scheduler picks the oldest one whose bank is free, so reads can pass each other when some banks are busy. Writes are sent only in cycles where no read can go.

Ordering is enforced for requests to the same location. A read and a write with the same bank and address are issued in the order they arrived. If both arrive in the same cycle, the read counts as the older one. A read that has waited too long stops all other reads until it goes out, but writes may still be issued in that time, so a blocking write can clear. Every issued read comes back on the completion port with its tag a fixed six cycles later, so requesters can match out-of-order completions.

Top module: `bankSched`

## Requirements
- R1: The read queue holds up to 8 requests. `rdReqReady` is high exactly while fewer than 8 reads are queued. A request is taken on a clock edge where both valid and ready are high, and no taken request is ever lost or overwritten.
- R2: The write queue holds up to 8 requests and is independent of the read queue. Its ready signal follows the same rule as in R1, and no taken write is lost.
- R3: After a command to bank b in cycle t, no command goes to bank b in cycles t+1 through t+5. Bank b may receive a command again in cycle t+6.
- R4: When reads can be issued, the command is the oldest queued read whose bank is free and which is not held by R6. Younger reads to free banks pass older reads that wait on busy banks.
- R5: A write is issued only in a cycle where no read is eligible. In that case the oldest write whose bank is free and which is not held by R6 is chosen.
- R6: Requests with equal bank and address issue in arrival order. A read does not go before an older queued write to the same location, and a write does not go before an older queued read to the same location. When a read and a write arrive in the same cycle, the read is the older one.
- R7: When the oldest queued read has waited 16 or more cycles since it was accepted, no other read is issued until that read issues. Writes are still allowed in those cycles under R5.
- R8: For each read command, `retValid` goes high with `retTag` equal to that read's tag exactly 6 cycles after the command cycle.
- R9: No command is issued in a cycle where every queued request targets a busy bank or is held by R6. No command is issued while both queues are empty.
- R10: After reset both queues are empty, both ready signals are high, and `cmdValid` and `retValid` are low.
- R11: A command carries the bank, address and tag of the queued request it serves. `cmdIsWrite` is 1 for writes and 0 for reads, and a write command carries its queued data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdReqValid | input | 1 | Read request present |
| rdReqReady | output | 1 | Read queue can take a request |
| rdReqBank | input | BANK_W | Read target bank |
| rdReqAddr | input | ADDR_W | Read row/column address |
| rdReqTag | input | TAG_W | Read identifier |
| wrReqValid | input | 1 | Write request present |
| wrReqReady | output | 1 | Write queue can take a request |
| wrReqBank | input | BANK_W | Write target bank |
| wrReqAddr | input | ADDR_W | Write row/column address |
| wrReqData | input | DATA_W | Write data |
| wrReqTag | input | TAG_W | Write identifier |
| cmdValid | output | 1 | A command is issued this cycle |
| cmdIsWrite | output | 1 | 1 = write command, 0 = read command |
| cmdBank | output | BANK_W | Command bank |
| cmdAddr | output | ADDR_W | Command address |
| cmdData | output | DATA_W | Write data (zero on reads) |
| cmdTag | output | TAG_W | Command identifier |
| retValid | output | 1 | Read completion |
| retTag | output | TAG_W | Tag of the completed read |

## Verification
Two things can happen on the same clock edge: a write command that clears a location, and the arrival of a new read to that same location. A third case is a read and a write to one location arriving together. The bench provokes both cases in directed phases and again in a random phase that limits addresses to four values across four banks, so these collisions happen often. Each case is judged by comparing every issued command, cycle by cycle, with a behavioural model that keeps per-read counts of the older writes still pending. The aging rule is provoked by keeping a hazard-held read's bank busy with other reads until the read reaches 16 cycles of waiting.

// File: rtl/schedPkg.sv
package schedPkg;
  localparam int QDEPTH = 8;
  localparam int SLOT_W = $clog2(QDEPTH);
  localparam int CNT_W  = SLOT_W + 1;

  typedef struct packed {
    logic              rdIssue;
    logic [SLOT_W-1:0] rdSlot;
    logic              wrIssue;
    logic [SLOT_W-1:0] wrSlot;
  } schedStrobe_t;
endpackage

// File: rtl/schedControl.sv
module schedControl
  import schedPkg::*;
(
  input  logic [QDEPTH-1:0] rdElig,
  input  logic [QDEPTH-1:0] wrElig,
  input  logic              urgent,
  output schedStrobe_t      stb
);
  logic [QDEPTH-1:0] rdMask;

  // an aged head read freezes every other read slot
  assign rdMask = urgent ? {{(QDEPTH-1){1'b0}}, rdElig[0]} : rdElig;

  always_comb begin
    stb = '0;
    for (int i = QDEPTH-1; i >= 0; i--) begin
      if (rdMask[i]) begin
        stb.rdIssue = 1'b1;
        stb.rdSlot  = SLOT_W'(i);
      end
      if (wrElig[i]) begin
        stb.wrIssue = 1'b1;
        stb.wrSlot  = SLOT_W'(i);
      end
    end
    if (stb.rdIssue) begin
      stb.wrIssue = 1'b0;
    end
  end
endmodule

// File: rtl/schedDatapath.sv
module schedDatapath
  import schedPkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 16,
  parameter int TAG_W     = 4,
  parameter int BUSY_CYC  = 6,
  parameter int RET_LAT   = 6,
  parameter int AGE_LIMIT = 16,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int TMR_W    = $clog2(BUSY_CYC) + 1,
  localparam int AGE_W    = $clog2(AGE_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdValid,
  output logic              rdReady,
  input  logic [BANK_W-1:0] rdBank,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [TAG_W-1:0]  rdTag,
  input  logic              wrValid,
  output logic              wrReady,
  input  logic [BANK_W-1:0] wrBank,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [TAG_W-1:0]  wrTag,
  input  schedStrobe_t      stb,
  output logic [QDEPTH-1:0] rdElig,
  output logic [QDEPTH-1:0] wrElig,
  output logic              urgent,
  output logic [CNT_W-1:0]  rdCnt,
  output logic [CNT_W-1:0]  wrCnt,
  output logic              cmdValid,
  output logic              cmdIsWrite,
  output logic [BANK_W-1:0] cmdBank,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [DATA_W-1:0] cmdData,
  output logic [TAG_W-1:0]  cmdTag,
  output logic              retValid,
  output logic [TAG_W-1:0]  retTag
);
  logic [BANK_W-1:0] rBank [QDEPTH], rBankN [QDEPTH], wBank [QDEPTH], wBankN [QDEPTH];
  logic [ADDR_W-1:0] rAddr [QDEPTH], rAddrN [QDEPTH], wAddr [QDEPTH], wAddrN [QDEPTH];
  logic [TAG_W-1:0]  rTag  [QDEPTH], rTagN  [QDEPTH], wTag  [QDEPTH], wTagN  [QDEPTH];
  logic [AGE_W-1:0]  rAge  [QDEPTH], rAgeN  [QDEPTH];
  logic [CNT_W-1:0]  rPend [QDEPTH], rPendN [QDEPTH];
  logic [DATA_W-1:0] wData [QDEPTH], wDataN [QDEPTH];
  logic [CNT_W-1:0]  rdCntN, wrCntN, rRem, wRem, inPend;
  logic [TMR_W-1:0]  bankTmr [NUM_BANKS];
  logic [QDEPTH-1:0] wHaz;
  logic [RET_LAT-1:0] pipeV;
  logic [TAG_W-1:0]  pipeT [RET_LAT];
  logic              rdAcc, wrAcc;

  assign rdReady = rdCnt < CNT_W'(QDEPTH);
  assign wrReady = wrCnt < CNT_W'(QDEPTH);
  assign rdAcc   = rdValid && rdReady;
  assign wrAcc   = wrValid && wrReady;
  assign urgent  = (rdCnt != '0) && (rAge[0] >= AGE_W'(AGE_LIMIT));

  // eligibility: bank idle and no same-location ordering hold
  always_comb begin
    for (int j = 0; j < QDEPTH; j++) begin
      wHaz[j] = 1'b0;
      for (int i = 0; i < QDEPTH; i++) begin
        if (CNT_W'(i) < rdCnt && rPend[i] == '0 &&
            rBank[i] == wBank[j] && rAddr[i] == wAddr[j]) wHaz[j] = 1'b1;
      end
      rdElig[j] = (CNT_W'(j) < rdCnt) && (bankTmr[rBank[j]] == '0) && (rPend[j] == '0);
      wrElig[j] = (CNT_W'(j) < wrCnt) && (bankTmr[wBank[j]] == '0) && !wHaz[j];
    end
  end

  always_comb begin
    cmdValid   = stb.rdIssue || stb.wrIssue;
    cmdIsWrite = stb.wrIssue;
    cmdBank    = stb.rdIssue ? rBank[stb.rdSlot] : wBank[stb.wrSlot];
    cmdAddr    = stb.rdIssue ? rAddr[stb.rdSlot] : wAddr[stb.wrSlot];
    cmdTag     = stb.rdIssue ? rTag[stb.rdSlot]  : wTag[stb.wrSlot];
    cmdData    = stb.wrIssue ? wData[stb.wrSlot] : '0;
  end

  // older writes to the incoming read's location, less one leaving now
  always_comb begin
    inPend = '0;
    for (int j = 0; j < QDEPTH; j++) begin
      if (CNT_W'(j) < wrCnt && wBank[j] == rdBank && wAddr[j] == rdAddr)
        inPend = inPend + CNT_W'(1);
    end
    if (stb.wrIssue && cmdBank == rdBank && cmdAddr == rdAddr)
      inPend = inPend - CNT_W'(1);
  end

  assign rRem   = rdCnt - CNT_W'(stb.rdIssue);
  assign wRem   = wrCnt - CNT_W'(stb.wrIssue);
  assign rdCntN = rRem + CNT_W'(rdAcc);
  assign wrCntN = wRem + CNT_W'(wrAcc);

  // compacting queues: slot 0 always holds the oldest entry
  always_comb begin
    for (int i = 0; i < QDEPTH; i++) begin
      int rs, ws;
      rs = (stb.rdIssue && SLOT_W'(i) >= stb.rdSlot && i < QDEPTH-1) ? i + 1 : i;
      ws = (stb.wrIssue && SLOT_W'(i) >= stb.wrSlot && i < QDEPTH-1) ? i + 1 : i;
      rBankN[i] = rBank[rs]; rAddrN[i] = rAddr[rs]; rTagN[i] = rTag[rs];
      rAgeN[i]  = (rAge[rs] >= AGE_W'(AGE_LIMIT)) ? rAge[rs] : rAge[rs] + AGE_W'(1);
      rPendN[i] = rPend[rs];
      if (stb.wrIssue && rPend[rs] != '0 && rBank[rs] == cmdBank && rAddr[rs] == cmdAddr)
        rPendN[i] = rPend[rs] - CNT_W'(1);
      if (CNT_W'(i) == rRem && rdAcc) begin
        rBankN[i] = rdBank; rAddrN[i] = rdAddr; rTagN[i] = rdTag;
        rAgeN[i]  = '0;     rPendN[i] = inPend;
      end
      wBankN[i] = wBank[ws]; wAddrN[i] = wAddr[ws]; wTagN[i] = wTag[ws]; wDataN[i] = wData[ws];
      if (CNT_W'(i) == wRem && wrAcc) begin
        wBankN[i] = wrBank; wAddrN[i] = wrAddr; wTagN[i] = wrTag; wDataN[i] = wrData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdCnt <= '0;
      wrCnt <= '0;
      for (int i = 0; i < QDEPTH; i++) begin
        rBank[i] <= '0; rAddr[i] <= '0; rTag[i] <= '0; rAge[i] <= '0; rPend[i] <= '0;
        wBank[i] <= '0; wAddr[i] <= '0; wTag[i] <= '0; wData[i] <= '0;
      end
    end else begin
      rdCnt <= rdCntN;
      wrCnt <= wrCntN;
      for (int i = 0; i < QDEPTH; i++) begin
        rBank[i] <= rBankN[i]; rAddr[i] <= rAddrN[i]; rTag[i] <= rTagN[i];
        rAge[i]  <= rAgeN[i];  rPend[i] <= rPendN[i];
        wBank[i] <= wBankN[i]; wAddr[i] <= wAddrN[i]; wTag[i] <= wTagN[i]; wData[i] <= wDataN[i];
      end
    end
  end

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                      bankTmr[b] <= '0;
        else if (cmdValid && cmdBank == BANK_W'(b))     bankTmr[b] <= TMR_W'(BUSY_CYC - 1);
        else if (bankTmr[b] != '0)                      bankTmr[b] <= bankTmr[b] - TMR_W'(1);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pipeV <= '0;
      for (int k = 0; k < RET_LAT; k++) pipeT[k] <= '0;
    end else begin
      pipeV    <= {pipeV[RET_LAT-2:0], stb.rdIssue};
      pipeT[0] <= cmdTag;
      for (int k = 1; k < RET_LAT; k++) pipeT[k] <= pipeT[k-1];
    end
  end

  assign retValid = pipeV[RET_LAT-1];
  assign retTag   = pipeT[RET_LAT-1];
endmodule

// File: rtl/bankSched.sv
module bankSched
  import schedPkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 16,
  parameter int TAG_W     = 4,
  parameter int BUSY_CYC  = 6,
  parameter int RET_LAT   = 6,
  parameter int AGE_LIMIT = 16,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdReqValid,
  output logic              rdReqReady,
  input  logic [BANK_W-1:0] rdReqBank,
  input  logic [ADDR_W-1:0] rdReqAddr,
  input  logic [TAG_W-1:0]  rdReqTag,
  input  logic              wrReqValid,
  output logic              wrReqReady,
  input  logic [BANK_W-1:0] wrReqBank,
  input  logic [ADDR_W-1:0] wrReqAddr,
  input  logic [DATA_W-1:0] wrReqData,
  input  logic [TAG_W-1:0]  wrReqTag,
  output logic              cmdValid,
  output logic              cmdIsWrite,
  output logic [BANK_W-1:0] cmdBank,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [DATA_W-1:0] cmdData,
  output logic [TAG_W-1:0]  cmdTag,
  output logic              retValid,
  output logic [TAG_W-1:0]  retTag
);
  schedStrobe_t      stb;
  logic [QDEPTH-1:0] rdElig, wrElig;
  logic              urgent;
  logic [CNT_W-1:0]  rdCnt, wrCnt;

  schedControl ctl_i (
    .rdElig(rdElig), .wrElig(wrElig), .urgent(urgent), .stb(stb)
  );

  schedDatapath #(
    .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W),
    .BUSY_CYC(BUSY_CYC), .RET_LAT(RET_LAT), .AGE_LIMIT(AGE_LIMIT)
  ) dp_i (
    .clk(clk), .rstN(rstN),
    .rdValid(rdReqValid), .rdReady(rdReqReady), .rdBank(rdReqBank),
    .rdAddr(rdReqAddr), .rdTag(rdReqTag),
    .wrValid(wrReqValid), .wrReady(wrReqReady), .wrBank(wrReqBank),
    .wrAddr(wrReqAddr), .wrData(wrReqData), .wrTag(wrReqTag),
    .stb(stb), .rdElig(rdElig), .wrElig(wrElig), .urgent(urgent),
    .rdCnt(rdCnt), .wrCnt(wrCnt),
    .cmdValid(cmdValid), .cmdIsWrite(cmdIsWrite), .cmdBank(cmdBank),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .cmdTag(cmdTag),
    .retValid(retValid), .retTag(retTag)
  );
endmodule

// File: rtl/bankSchedChecker.sv
module bankSchedChecker
  import schedPkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int TAG_W     = 4,
  parameter int BUSY_CYC  = 6,
  parameter int RET_LAT   = 6,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int TMR_W    = $clog2(BUSY_CYC) + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdReqValid,
  input logic              rdReqReady,
  input logic              wrReqValid,
  input logic              wrReqReady,
  input logic              cmdValid,
  input logic              cmdIsWrite,
  input logic [BANK_W-1:0] cmdBank,
  input logic [TAG_W-1:0]  cmdTag,
  input logic              retValid,
  input logic [TAG_W-1:0]  retTag,
  input logic [CNT_W-1:0]  rdCnt,
  input logic [CNT_W-1:0]  wrCnt
);
  logic [TMR_W-1:0]   restCnt [NUM_BANKS];
  logic [RET_LAT-1:0] seenV;
  logic [TAG_W-1:0]   seenT [RET_LAT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seenV <= '0;
      for (int k = 0; k < RET_LAT; k++) seenT[k] <= '0;
    end else begin
      seenV    <= {seenV[RET_LAT-2:0], cmdValid && !cmdIsWrite};
      seenT[0] <= cmdTag;
      for (int k = 1; k < RET_LAT; k++) seenT[k] <= seenT[k-1];
    end
  end

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_rest
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                  restCnt[b] <= '0;
        else if (cmdValid && cmdBank == BANK_W'(b)) restCnt[b] <= TMR_W'(BUSY_CYC - 1);
        else if (restCnt[b] != '0)                  restCnt[b] <= restCnt[b] - TMR_W'(1);
      end
      a_r3_bank_rest: assert property (@(posedge clk) disable iff (!rstN)
        (cmdValid && cmdBank == BANK_W'(b)) |-> restCnt[b] == '0);
    end
  endgenerate

  a_r1_rd_taken: assert property (@(posedge clk) disable iff (!rstN)
    (rdReqValid && rdReqReady && !(cmdValid && !cmdIsWrite)) |=> rdCnt == $past(rdCnt) + CNT_W'(1));

  a_r1_rd_full_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rdCnt == CNT_W'(QDEPTH) && !(cmdValid && !cmdIsWrite)) |=> rdCnt == CNT_W'(QDEPTH));

  a_r2_wr_taken: assert property (@(posedge clk) disable iff (!rstN)
    (wrReqValid && wrReqReady && !(cmdValid && cmdIsWrite)) |=> wrCnt == $past(wrCnt) + CNT_W'(1));

  a_r8_ret_slot: assert property (@(posedge clk) disable iff (!rstN)
    retValid == seenV[RET_LAT-1]);

  a_r8_ret_tag: assert property (@(posedge clk) disable iff (!rstN)
    retValid |-> retTag == seenT[RET_LAT-1]);

  a_r9_empty_idle: assert property (@(posedge clk) disable iff (!rstN)
    (rdCnt == '0 && wrCnt == '0) |-> !cmdValid);
endmodule

bind bankSched bankSchedChecker #(
  .NUM_BANKS(NUM_BANKS), .TAG_W(TAG_W), .BUSY_CYC(BUSY_CYC), .RET_LAT(RET_LAT)
) chk_i (
  .clk(clk), .rstN(rstN), .rdReqValid(rdReqValid), .rdReqReady(rdReqReady),
  .wrReqValid(wrReqValid), .wrReqReady(wrReqReady), .cmdValid(cmdValid),
  .cmdIsWrite(cmdIsWrite), .cmdBank(cmdBank), .cmdTag(cmdTag),
  .retValid(retValid), .retTag(retTag), .rdCnt(rdCnt), .wrCnt(wrCnt)
);

// File: tb/bankSched_tb_top.sv
module bankSched_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int QD = 8;
  localparam int BUSY = 6;
  localparam int LAT = 6;
  localparam int AGE_LIM = 16;

  logic clk = 1'b0, rstN = 1'b0;
  logic rdReqValid = 0, wrReqValid = 0;
  logic [1:0] rdReqBank = 0, wrReqBank = 0;
  logic [11:0] rdReqAddr = 0, wrReqAddr = 0;
  logic [15:0] wrReqData = 0;
  logic [3:0] rdReqTag = 0, wrReqTag = 0;
  logic rdReqReady, wrReqReady, cmdValid, cmdIsWrite, retValid;
  logic [1:0] cmdBank;
  logic [11:0] cmdAddr;
  logic [15:0] cmdData;
  logic [3:0] cmdTag, retTag;

  always #(CLK_PERIOD/2) clk = ~clk;

  bankSched dut_i (
    .clk(clk), .rstN(rstN),
    .rdReqValid(rdReqValid), .rdReqReady(rdReqReady), .rdReqBank(rdReqBank),
    .rdReqAddr(rdReqAddr), .rdReqTag(rdReqTag),
    .wrReqValid(wrReqValid), .wrReqReady(wrReqReady), .wrReqBank(wrReqBank),
    .wrReqAddr(wrReqAddr), .wrReqData(wrReqData), .wrReqTag(wrReqTag),
    .cmdValid(cmdValid), .cmdIsWrite(cmdIsWrite), .cmdBank(cmdBank),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .cmdTag(cmdTag),
    .retValid(retValid), .retTag(retTag)
  );

  typedef struct { int bank; int addr; int tag; int age; int pend; } rdEnt_t;
  typedef struct { int bank; int addr; int data; int tag; } wrEnt_t;
  rdEnt_t rq[$];
  wrEnt_t wq[$];
  int tmr[NB];
  int pipeV[LAT];
  int pipeT[LAT];
  int lastCmd[NB];
  int checks = 0, failures = 0, cycleNo = 0, tagSeq = 0;
  bit done = 0;

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s cycle=%0d actual=%0d expected=%0d", req, what, cycleNo, act, exp);
    end
  endtask

  function automatic bit wrHeld(int j);
    foreach (rq[i]) if (rq[i].pend == 0 && rq[i].bank == wq[j].bank && rq[i].addr == wq[j].addr) return 1;
    return 0;
  endfunction

  // compare at this negedge, then advance the model with the inputs now driven
  task automatic cycle(string req);
    int selR = -1, selW = -1, eb = 0, ea = 0, et = 0, ed = 0;
    bit urg;
    urg = rq.size() > 0 && rq[0].age >= AGE_LIM;
    foreach (rq[i]) begin
      if (selR < 0 && !(urg && i > 0) && tmr[rq[i].bank] == 0 && rq[i].pend == 0) selR = i;
    end
    if (selR < 0) foreach (wq[j]) begin
      if (selW < 0 && tmr[wq[j].bank] == 0 && !wrHeld(j)) selW = j;
    end
    if (selR >= 0) begin eb = rq[selR].bank; ea = rq[selR].addr; et = rq[selR].tag; end
    if (selW >= 0) begin eb = wq[selW].bank; ea = wq[selW].addr; et = wq[selW].tag; ed = wq[selW].data; end

    check(req, "cmdValid", int'(cmdValid), int'(selR >= 0 || selW >= 0));
    if (cmdValid && (selR >= 0 || selW >= 0)) begin
      check("R11", "cmdIsWrite", int'(cmdIsWrite), int'(selW >= 0));
      check("R11", "cmdBank", int'(cmdBank), eb);
      check("R11", "cmdAddr", int'(cmdAddr), ea);
      check("R11", "cmdTag", int'(cmdTag), et);
      if (selW >= 0) check("R11", "cmdData", int'(cmdData), ed);
    end
    if (cmdValid) begin
      check("R3", "bank rest gap ok", int'(cycleNo - lastCmd[cmdBank] >= BUSY), 1);
      lastCmd[cmdBank] = cycleNo;
    end
    check("R1", "rdReqReady", int'(rdReqReady), int'(rq.size() < QD));
    check("R2", "wrReqReady", int'(wrReqReady), int'(wq.size() < QD));
    check("R8", "retValid", int'(retValid), pipeV[LAT-1]);
    if (retValid && pipeV[LAT-1] != 0) check("R8", "retTag", int'(retTag), pipeT[LAT-1]);

    begin
      int rsz = rq.size(), wsz = wq.size();
      for (int k = LAT-1; k > 0; k--) begin pipeV[k] = pipeV[k-1]; pipeT[k] = pipeT[k-1]; end
      pipeV[0] = int'(selR >= 0);
      pipeT[0] = et;
      for (int b = 0; b < NB; b++) if (tmr[b] > 0) tmr[b]--;
      if (selR >= 0 || selW >= 0) tmr[eb] = BUSY - 1;
      if (selR >= 0) rq.delete(selR);
      if (selW >= 0) begin
        wq.delete(selW);
        foreach (rq[i]) if (rq[i].pend > 0 && rq[i].bank == eb && rq[i].addr == ea) rq[i].pend--;
      end
      foreach (rq[i]) if (rq[i].age < 31) rq[i].age++;
      if (rdReqValid && rsz < QD) begin
        rdEnt_t n;
        n.bank = int'(rdReqBank); n.addr = int'(rdReqAddr); n.tag = int'(rdReqTag);
        n.age = 0; n.pend = 0;
        foreach (wq[j]) if (wq[j].bank == n.bank && wq[j].addr == n.addr) n.pend++;
        rq.push_back(n);
      end
      if (wrReqValid && wsz < QD) begin
        wrEnt_t w;
        w.bank = int'(wrReqBank); w.addr = int'(wrReqAddr);
        w.data = int'(wrReqData); w.tag = int'(wrReqTag);
        wq.push_back(w);
      end
    end
    cycleNo++;
    @(negedge clk);
  endtask

  task automatic drive(bit rv, int rb, int ra, bit wv, int wb, int wa);
    rdReqValid = rv; rdReqBank = 2'(rb); rdReqAddr = 12'(ra); rdReqTag = 4'(tagSeq);
    wrReqValid = wv; wrReqBank = 2'(wb); wrReqAddr = 12'(wa); wrReqTag = 4'(tagSeq + 1);
    wrReqData = 16'(16'h1000 + tagSeq * 7);
    tagSeq = (tagSeq + 2) % 16;
  endtask

  task automatic idle(int n, string req);
    for (int k = 0; k < n; k++) begin drive(0, 0, 0, 0, 0, 0); cycle(req); end
  endtask

  initial begin
    for (int b = 0; b < NB; b++) begin tmr[b] = 0; lastCmd[b] = -100; end
    for (int k = 0; k < LAT; k++) begin pipeV[k] = 0; pipeT[k] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R10: state right after reset
    check("R10", "rdReqReady", int'(rdReqReady), 1);
    check("R10", "wrReqReady", int'(wrReqReady), 1);
    check("R10", "retValid", int'(retValid), 0);
    idle(2, "R10");

    // R3: back-to-back reads to one bank are spaced six cycles apart
    for (int k = 0; k < 3; k++) begin drive(1, 0, 16 + k, 0, 0, 0); cycle("R3"); end
    idle(20, "R3");

    // R4: a younger read to a free bank passes reads stuck on a busy bank
    drive(1, 0, 1, 0, 0, 0); cycle("R4");
    drive(1, 0, 2, 0, 0, 0); cycle("R4");
    drive(1, 1, 3, 0, 0, 0); cycle("R4");
    drive(1, 2, 4, 0, 0, 0); cycle("R4");
    idle(20, "R4");

    // R5: a write fills in while the pending reads wait on a busy bank
    drive(1, 0, 5, 1, 2, 6); cycle("R5");
    drive(1, 0, 7, 1, 3, 8); cycle("R5");
    drive(1, 0, 9, 0, 0, 0); cycle("R5");
    idle(25, "R5");

    // R6: read-then-write, write-then-read and same-cycle pairs
    drive(1, 1, 40, 0, 0, 0); cycle("R6");
    drive(1, 1, 41, 1, 1, 41); cycle("R6");
    drive(0, 0, 0, 1, 3, 42); cycle("R6");
    drive(1, 3, 42, 1, 2, 43); cycle("R6");
    drive(1, 2, 43, 1, 1, 40); cycle("R6");
    idle(30, "R6");

    // R7: a hazard-held read ages out while its bank stays busy with other reads
    drive(0, 0, 0, 1, 0, 80); cycle("R7");
    drive(1, 0, 80, 0, 0, 0); cycle("R7");
    for (int k = 0; k < 30; k++) begin
      drive(k % 2 == 0, 0, 100 + k, 0, 0, 0); cycle("R7");
    end
    idle(60, "R7");

    // R1, R2: fill both queues past capacity
    for (int k = 0; k < 12; k++) begin drive(1, 0, 200 + k, 1, 0, 300 + k); cycle("R1"); end
    idle(10, "R2");
    for (int k = 0; k < 12; k++) begin drive(0, 0, 0, 1, 1, 400 + k); cycle("R2"); end
    idle(150, "R9");

    // random phase with few addresses so locations collide often
    for (int k = 0; k < 600; k++) begin
      drive(($urandom % 3) != 0, $urandom % 4, $urandom % 4,
            ($urandom % 3) == 0, $urandom % 4, $urandom % 4);
      cycle("R4");
    end
    idle(200, "R9");
    check("R9", "read queue drained", rq.size(), 0);
    check("R9", "write queue drained", wq.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule